// File: doc/BRIEF.md
# Iterative Double-Word Logical Right Shifter

This execution unit shifts a 32-bit operand toward the least significant end, one bit position per clock, for a count chosen at launch. Vacated upper bits take zeros, so each step is an unsigned halving. The unit reports the final value along with a set of status flags. The carry flag holds the last bit that left the operand. The sticky flag records whether a 1 sat in the carry position and was then displaced by a further step.

A pipeline front end supplies the count byte. When `imm_sel_i` is high, the byte carries an immediate count, and only its low four bits are used. When `imm_sel_i` is low, the byte is a value already fetched from a register, and its low five bits are used. A single `start_i` pulse launches the operation. `busy_o` stays high while the iterations run. A one-cycle `done_o` pulse marks the cycle in which the result and all flags become valid. Those outputs then hold until the next completion.

Top module: `dw_rshift_unit`

## Requirements
- R1: While reset is asserted and after its release, before any operation, result, all flags, `busy_o` and `done_o` read zero.
- R2: With `imm_sel_i` low, the shift amount N is `count_i[4:0]` and the upper count bits have no effect. The result is the operand shifted right logically by N, with zeros entering at bit 31.
- R3: With `imm_sel_i` high, the shift amount N is `count_i[3:0]` and bits 7..4 of the count byte have no effect.
- R4: `carry_o` equals operand bit N-1 for N of 1 or more, and is 0 for N = 0.
- R5: `sticky_o` is cleared at launch. It is 1 exactly when some bit of operand[N-2:0] is 1, so a 1 entered carry and another step followed. For N below 2 it is 0.
- R6: `zero_o` is 1 exactly when the 32-bit result is all zeros. `neg_o` and `ovf_o` are always 0.
- R7: `done_o` is high for exactly one cycle, N+1 clock edges after the edge that accepts `start_i`. A count of 0 therefore completes one cycle after launch.
- R8: `busy_o` is high from the cycle after an accepted start until `done_o` rises, and is low while `done_o` is high.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running operation's result, flags and completion timing are unchanged.
- R10: Result and flags change only together with `done_o` and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe, accepted when idle |
| imm_sel_i | input | 1 | 1: count byte is immediate (4 bits used); 0: register-sourced (5 bits used) |
| count_i | input | 8 | Count byte |
| operand_i | input | 32 | Value to shift |
| result_o | output | 32 | Shifted value, valid from `done_o` |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Negative flag, always cleared |
| carry_o | output | 1 | Last bit shifted out |
| ovf_o | output | 1 | Overflow flag, always cleared |
| sticky_o | output | 1 | A 1 passed through carry and was then shifted out |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every register-sourced count from 0 to 31 is run against a random operand, with random junk in the unused count bits. Every immediate count from 0 to 15 is run with junk in the top nibble. Together these separate a wrong mask width from a wrong shift distance, and they confirm the N+1 completion latency. Directed operands then isolate single set bits just below, at and above the final carry position. Such an operand shows whether sticky is driven by the earlier displaced bits or wrongly by the last one. All-ones and zero operands exercise the zero flag. Start pulses injected mid-run show that a busy unit ignores a second launch.

// File: rtl/dwsh_pkg.sv
`timescale 1ns/1ps
package dwsh_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dwsh_state_e;

   typedef struct packed {
      logic zero;
      logic neg;
      logic carry;
      logic ovf;
      logic sticky;
   } dwsh_flags_t;

   function automatic int unsigned dwsh_clog2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/dwsh_count_qual.sv
`timescale 1ns/1ps
module dwsh_count_qual #(
   parameter int CNT_W    = 8,
   parameter int IMM_BITS = 4,
   parameter int REG_BITS = 5
) (
   input  logic                imm_sel_i,
   input  logic [CNT_W-1:0]    count_i,
   output logic [REG_BITS-1:0] amount_o
);

   logic [REG_BITS-1:0] reg_amt;
   logic [REG_BITS-1:0] imm_amt;

   assign reg_amt = count_i[REG_BITS-1:0];

   generate
      if (IMM_BITS == REG_BITS) begin : g_same_width
         assign imm_amt = count_i[REG_BITS-1:0];
      end else begin : g_narrow_imm
         assign imm_amt = {{(REG_BITS-IMM_BITS){1'b0}}, count_i[IMM_BITS-1:0]};
      end

      if (CNT_W > REG_BITS) begin : g_spare_bits
         logic unused_hi;
         assign unused_hi = ^count_i[CNT_W-1:REG_BITS];
      end
   endgenerate

   assign amount_o = imm_sel_i ? imm_amt : reg_amt;

endmodule

// File: rtl/dwsh_ctrl.sv
`timescale 1ns/1ps
module dwsh_ctrl
   import dwsh_pkg::*;
#(
   parameter int AMT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [AMT_W-1:0] amount_i,
   output logic             load_o,
   output logic             step_o,
   output logic             finish_o,
   output logic             busy_o,
   output logic             done_o
);

   dwsh_state_e      state_q, state_d;
   logic [AMT_W-1:0] left_q, left_d;
   logic             done_q;

   always_comb begin
      state_d  = state_q;
      left_d   = left_q;
      load_o   = 1'b0;
      step_o   = 1'b0;
      finish_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               left_d  = amount_i;
               state_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (left_q == '0) begin
               finish_o = 1'b1;
               state_d  = ST_IDLE;
            end else begin
               step_o = 1'b1;
               left_d = left_q - 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= left_d;
         done_q  <= finish_o;
      end
   end

   assign busy_o = (state_q == ST_RUN);
   assign done_o = done_q;

endmodule

// File: rtl/dwsh_datapath.sv
`timescale 1ns/1ps
module dwsh_datapath #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] operand_i,
   output logic [DATA_W-1:0] value_o,
   output logic              carry_o,
   output logic              sticky_o
);

   logic [DATA_W-1:0] val_q;
   logic              cy_q;
   logic              st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         cy_q  <= 1'b0;
         st_q  <= 1'b0;
      end else if (load_i) begin
         val_q <= operand_i;
         cy_q  <= 1'b0;
         st_q  <= 1'b0;
      end else if (step_i) begin
         st_q  <= st_q | cy_q;
         cy_q  <= val_q[0];
         val_q <= {1'b0, val_q[DATA_W-1:1]};
      end
   end

   assign value_o  = val_q;
   assign carry_o  = cy_q;
   assign sticky_o = st_q;

endmodule

// File: rtl/dwsh_outreg.sv
`timescale 1ns/1ps
module dwsh_outreg
   import dwsh_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [DATA_W-1:0] value_i,
   input  logic              carry_i,
   input  logic              sticky_i,
   output logic [DATA_W-1:0] result_o,
   output dwsh_flags_t       flags_o
);

   logic [DATA_W-1:0] res_q;
   dwsh_flags_t       flg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
         flg_q <= '0;
      end else if (capture_i) begin
         res_q        <= value_i;
         flg_q.zero   <= (value_i == '0);
         flg_q.neg    <= 1'b0;
         flg_q.carry  <= carry_i;
         flg_q.ovf    <= 1'b0;
         flg_q.sticky <= sticky_i;
      end
   end

   assign result_o = res_q;
   assign flags_o  = flg_q;

endmodule

// File: rtl/dw_rshift_unit.sv
`timescale 1ns/1ps
module dw_rshift_unit
   import dwsh_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 8,
   parameter int IMM_BITS = 4,
   parameter int REG_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              imm_sel_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [DATA_W-1:0] operand_i,
   output logic [DATA_W-1:0] result_o,
   output logic              zero_o,
   output logic              neg_o,
   output logic              carry_o,
   output logic              ovf_o,
   output logic              sticky_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int MAX_AMT = (1 << REG_BITS) - 1;

   generate
      if (IMM_BITS < 1 || IMM_BITS > REG_BITS) begin : g_bad_imm
         $error("IMM_BITS must lie between 1 and REG_BITS");
      end
      if (REG_BITS > CNT_W) begin : g_bad_reg
         $error("REG_BITS must not exceed CNT_W");
      end
      if (MAX_AMT >= DATA_W) begin : g_bad_span
         $error("largest shift amount must be below DATA_W");
      end
   endgenerate

   logic [REG_BITS-1:0] amount;
   logic                load, step, finish;
   logic [DATA_W-1:0]   value;
   logic                dp_carry, dp_sticky;
   dwsh_flags_t         flags;

   dwsh_count_qual #(
      .CNT_W    (CNT_W),
      .IMM_BITS (IMM_BITS),
      .REG_BITS (REG_BITS)
   ) u_qual (
      .imm_sel_i (imm_sel_i),
      .count_i   (count_i),
      .amount_o  (amount)
   );

   dwsh_ctrl #(
      .AMT_W (REG_BITS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .amount_i (amount),
      .load_o   (load),
      .step_o   (step),
      .finish_o (finish),
      .busy_o   (busy_o),
      .done_o   (done_o)
   );

   dwsh_datapath #(
      .DATA_W (DATA_W)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .step_i    (step),
      .operand_i (operand_i),
      .value_o   (value),
      .carry_o   (dp_carry),
      .sticky_o  (dp_sticky)
   );

   dwsh_outreg #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (finish),
      .value_i   (value),
      .carry_i   (dp_carry),
      .sticky_i  (dp_sticky),
      .result_o  (result_o),
      .flags_o   (flags)
   );

   assign zero_o   = flags.zero;
   assign neg_o    = flags.neg;
   assign carry_o  = flags.carry;
   assign ovf_o    = flags.ovf;
   assign sticky_o = flags.sticky;

endmodule

// File: rtl/dwsh_chk.sv
`timescale 1ns/1ps
module dwsh_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] result_o,
   input logic              zero_o,
   input logic              carry_o,
   input logic              sticky_o
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
   AST_BUSY_EXCL_DONE: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o)); // R8
   AST_START_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R8
   AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_o) |-> $past(busy_o)); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(result_o)); // R10
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> ($stable(carry_o) && $stable(sticky_o) && $stable(zero_o))); // R10
   AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (zero_o == (result_o == '0))); // R6

endmodule

bind dw_rshift_unit dwsh_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .result_o (result_o),
   .zero_o   (zero_o),
   .carry_o  (carry_o),
   .sticky_o (sticky_o)
);

// File: tb/sim_dw_rshift_unit.sv
`timescale 1ns/1ps
module sim_dw_rshift_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        imm_sel_i = 1'b0;
   logic [7:0]  count_i = '0;
   logic [31:0] operand_i = '0;
   logic [31:0] result_o;
   logic        zero_o, neg_o, carry_o, ovf_o, sticky_o, busy_o, done_o;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   dw_rshift_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .imm_sel_i (imm_sel_i),
      .count_i   (count_i),
      .operand_i (operand_i),
      .result_o  (result_o),
      .zero_o    (zero_o),
      .neg_o     (neg_o),
      .carry_o   (carry_o),
      .ovf_o     (ovf_o),
      .sticky_o  (sticky_o),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_amount(input logic [7:0] cb, input logic imm);
      return imm ? int'(cb[3:0]) : int'(cb[4:0]);
   endfunction

   function automatic logic [31:0] exp_result(input logic [31:0] op, input int n);
      return op >> n;
   endfunction

   function automatic logic exp_carry(input logic [31:0] op, input int n);
      return (n == 0) ? 1'b0 : op[n-1];
   endfunction

   function automatic logic exp_sticky(input logic [31:0] op, input int n);
      logic [63:0] m;
      if (n < 2) return 1'b0;
      m = (64'd1 << (n - 1)) - 64'd1;
      return |({32'd0, op} & m);
   endfunction

   task automatic run_op(input logic [31:0] op, input logic [7:0] cb, input logic imm,
                         input bit poke, input string tag);
      int n;
      int k;
      logic [31:0] er;
      n  = exp_amount(cb, imm);
      er = exp_result(op, n);
      @(negedge clk);
      operand_i = op; count_i = cb; imm_sel_i = imm; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o && !done_o, {tag, " R8 busy after start"}, {busy_o, done_o}, 2'b10);
      if (poke) begin
         operand_i = ~op; count_i = 8'h1F; imm_sel_i = 1'b0; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      k = 1;
      while (!done_o && k < 40) begin
         if (!busy_o) chk(1'b0, {tag, " R8 busy dropped early"}, k, n + 1);
         @(negedge clk);
         k++;
      end
      chk(k == n + 1, {tag, poke ? " R9 latency with poke" : " R7 latency"}, k, n + 1);
      chk(!busy_o, {tag, " R8 busy low at done"}, busy_o, 0);
      chk(result_o == er, {tag, imm ? " R3 result" : (poke ? " R9 result" : " R2 result")}, result_o, er);
      chk(carry_o == exp_carry(op, n), {tag, " R4 carry"}, carry_o, exp_carry(op, n));
      chk(sticky_o == exp_sticky(op, n), {tag, " R5 sticky"}, sticky_o, exp_sticky(op, n));
      chk(zero_o == (er == 0) && !neg_o && !ovf_o, {tag, " R6 zero/neg/ovf"},
          {zero_o, neg_o, ovf_o}, {(er == 0), 2'b00});
      @(negedge clk);
      chk(!done_o, {tag, " R7 single pulse"}, done_o, 0);
      chk(result_o == er && carry_o == exp_carry(op, n), {tag, " R10 hold"}, result_o, er);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      logic [31:0] op;
      logic [7:0]  cb;
      void'($urandom(32'h5EED_0C01));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(result_o == 0 && !zero_o && !carry_o && !sticky_o && !busy_o && !done_o,
          "R1 in reset", result_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(result_o == 0 && !busy_o && !done_o && !carry_o && !sticky_o, "R1 after release", result_o, 0);

      // R2: every register-sourced count with junk in bits 7..5
      for (int c = 0; c < 32; c++) begin
         op = $urandom();
         cb = {3'($urandom()), 5'(c)};
         run_op(op, cb, 1'b0, 1'b0, "R2 sweep");
      end
      // R3: every immediate count with junk in bits 7..4
      for (int c = 0; c < 16; c++) begin
         op = $urandom();
         cb = {4'($urandom() | 1), 4'(c)};
         run_op(op, cb, 1'b1, 1'b0, "R3 sweep");
      end
      // R5 directed sticky cases
      run_op(32'h0000_0001, 8'h02, 1'b0, 1'b0, "R5 one then shift");
      run_op(32'h0000_0002, 8'h02, 1'b0, 1'b0, "R5 last only");
      run_op(32'h0000_0001, 8'h01, 1'b0, 1'b0, "R5 single step");
      run_op(32'h0000_0010, 8'h05, 1'b1, 1'b0, "R5 bit at carry");
      run_op(32'h0000_0010, 8'h06, 1'b1, 1'b0, "R5 bit below carry");
      run_op(32'h0000_0020, 8'h05, 1'b1, 1'b0, "R5 bit above carry");
      // R6 zero flag and extremes
      run_op(32'hFFFF_FFFF, 8'h1F, 1'b0, 1'b0, "R6 all ones max");
      run_op(32'h0000_0000, 8'h00, 1'b0, 1'b0, "R6 zero operand");
      run_op(32'h0000_0007, 8'h03, 1'b0, 1'b0, "R6 shift to zero");
      // R9 start pulses while busy
      run_op(32'h8000_0001, 8'h04, 1'b0, 1'b1, "R9 poke");
      run_op(32'h1234_5678, 8'h00, 1'b0, 1'b1, "R9 poke zero count");
      run_op(32'hDEAD_BEEF, 8'h09, 1'b1, 1'b1, "R9 poke imm");
      // mixed random traffic
      for (int i = 0; i < 40; i++) begin
         run_op($urandom(), 8'($urandom()), 1'($urandom()), ($urandom() % 4) == 0, "R2 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule